// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block watches the write cycles that a host makes to a byte-wide flash and recognises the multi-cycle command sequences that the flash accepts. Each write is presented as a single-clock strobe with an address and a data byte. Every multi-cycle command opens with the same two-write unlock prefix. A third command byte then selects one of four routes: a byte program, a longer erase or lock sequence, identification entry, or identification exit. When a sequence completes, the decoder emits a one-cycle command pulse. For a program command it also presents the captured target address and data. For a sector erase it presents the captured sector address.

The decoder also holds an identification-mode flag. A single stand-alone exit byte written to any address leaves that mode, as does the three-write exit form. While the status logic reports an embedded operation in progress, writes are ignored and the sequence position is held.

States: IDLE (no sequence in progress), UNL1 (first unlock write seen), UNL2 (unlock prefix complete, waiting for the command byte), PROG (program armed, waiting for the target write), ER1 / ER2 / ER3 (second unlock pair of the six-write family in progress). Transitions: IDLE→UNL1 on AA at 5555; UNL1→UNL2 on 55 at 2AAA; UNL2→PROG on A0 at 5555; UNL2→ER1 on 80 at 5555; UNL2→IDLE with identification entry (90 at 5555) or exit (F0 at 5555); PROG→IDLE with program issued on any write; ER1→ER2 on AA at 5555; ER2→ER3 on 55 at 2AAA; ER3→IDLE with chip erase (10 at 5555), lock enable (40 at 5555) or sector erase (30 at any address); IDLE→IDLE with identification exit on F0 at any address; any state→IDLE on any other write.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset all command pulses are low, the identification flag is low and the machine is in IDLE.
- R2: The writes AA@5555, 55@2AAA, A0@5555 and then any address/data give a program pulse in the cycle after the fourth write, with cmd_addr and cmd_data equal to that fourth write.
- R3: The writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 10@5555 give one chip-erase pulse in the cycle after the sixth write.
- R4: The same five writes followed by 30 at any address give one sector-erase pulse, with cmd_addr equal to that sixth write's address.
- R5: The same five writes followed by 40@5555 give one lock-enable pulse.
- R6: The writes AA@5555, 55@2AAA, 90@5555 give an identification-entry pulse, and id_mode reads 1 from that cycle on.
- R7: An exit pulse is given, and id_mode cleared, either by AA@5555, 55@2AAA, F0@5555, or by a single F0 written to any address while in IDLE.
- R8: A write whose address or data does not match the current step returns the machine to IDLE and issues no command.
- R9: Only address bits 14:0 are compared against 5555 and 2AAA. Higher address bits are ignored.
- R10: While busy is high, writes issue nothing and leave the sequence position unchanged. The sequence continues once busy falls.
- R11: At most one command pulse is high in any cycle, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 18 | Write address |
| wr_data | input | 8 | Write data |
| busy | input | 1 | Embedded operation in progress; blocks decoding |
| prog_pulse | output | 1 | Byte program command |
| sect_erase_pulse | output | 1 | Sector erase command |
| chip_erase_pulse | output | 1 | Chip erase command |
| lock_pulse | output | 1 | Boot-region lock enable command |
| id_enter_pulse | output | 1 | Identification-mode entry |
| id_exit_pulse | output | 1 | Identification-mode exit |
| cmd_addr | output | 18 | Captured program target or sector address |
| cmd_data | output | 8 | Captured program data |
| id_mode | output | 1 | Identification mode active |

## Verification
Every cycle, the assertions check four things: no two command pulses coincide; a pulse only follows an accepted write; captured address and data match the issuing write; id_mode changes only together with the matching entry or exit pulse. They also check that a busy cycle freezes the state and issues nothing. The scenarios are needed to show that each full sequence yields the right command. They also show that partial or corrupted sequences yield nothing, that upper address bits are ignored, and that a sequence interrupted by busy resumes at the same step.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam logic [14:0] KEY_ADDR_A = 15'h5555;
    localparam logic [14:0] KEY_ADDR_B = 15'h2AAA;

    typedef enum logic [3:0] {
        C_AA, C_55, C_A0, C_80, C_90, C_F0, C_10, C_30, C_40, C_OTHER
    } cmd_code_t;

    typedef enum logic [2:0] {
        S_IDLE, S_UNL1, S_UNL2, S_PROG, S_ER1, S_ER2, S_ER3
    } seq_state_t;

    typedef struct packed {
        logic prog;
        logic sect;
        logic chip;
        logic lock;
        logic id_in;
        logic id_out;
    } cmd_set_t;

endpackage

// File: rtl/cmd_match.sv
module cmd_match
    import flash_cmd_pkg::*;
#(
    parameter int CMP_W  = 15,
    parameter int DATA_W = 8
) (
    input  logic [CMP_W-1:0]  low_addr,
    input  logic [DATA_W-1:0] data,
    output logic              hit_a,
    output logic              hit_b,
    output cmd_code_t         code
);

    always_comb begin
        hit_a = (low_addr == KEY_ADDR_A[CMP_W-1:0]);
        hit_b = (low_addr == KEY_ADDR_B[CMP_W-1:0]);
    end

    always_comb begin
        case (data)
            8'hAA:   code = C_AA;
            8'h55:   code = C_55;
            8'hA0:   code = C_A0;
            8'h80:   code = C_80;
            8'h90:   code = C_90;
            8'hF0:   code = C_F0;
            8'h10:   code = C_10;
            8'h30:   code = C_30;
            8'h40:   code = C_40;
            default: code = C_OTHER;
        endcase
    end

endmodule

// File: rtl/cmd_fsm.sv
module cmd_fsm
    import flash_cmd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  logic      busy,
    input  logic      hit_a,
    input  logic      hit_b,
    input  cmd_code_t code,
    output cmd_set_t  issue
);

    seq_state_t st, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt   = st;
        issue = '0;
        if (wr_en && !busy) begin
            nxt = S_IDLE;
            unique case (st)
                S_IDLE: begin
                    if (hit_a && code == C_AA) nxt = S_UNL1;
                    else if (code == C_F0)     issue.id_out = 1'b1;
                end
                S_UNL1: if (hit_b && code == C_55) nxt = S_UNL2;
                S_UNL2: begin
                    if (hit_a) begin
                        case (code)
                            C_A0:    nxt = S_PROG;
                            C_80:    nxt = S_ER1;
                            C_90:    issue.id_in  = 1'b1;
                            C_F0:    issue.id_out = 1'b1;
                            default: nxt = S_IDLE;
                        endcase
                    end
                end
                S_PROG: issue.prog = 1'b1;
                S_ER1:  if (hit_a && code == C_AA) nxt = S_ER2;
                S_ER2:  if (hit_b && code == C_55) nxt = S_ER3;
                S_ER3: begin
                    if (code == C_30)               issue.sect = 1'b1;
                    else if (hit_a && code == C_10) issue.chip = 1'b1;
                    else if (hit_a && code == C_40) issue.lock = 1'b1;
                end
                default: nxt = S_IDLE;
            endcase
        end
    end

    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (st == $past(st)));

    assert_busy_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (issue == '0));

    assert_cmd_needs_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue != '0) |-> wr_en);

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (st == S_IDLE));

endmodule

// File: rtl/cmd_capture.sv
module cmd_capture
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_set_t          issue,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output cmd_set_t          pulses,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic              id_mode
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulses   <= '0;
            cmd_addr <= '0;
            cmd_data <= '0;
            id_mode  <= 1'b0;
        end else begin
            pulses <= issue;
            if (issue.prog || issue.sect) cmd_addr <= wr_addr;
            if (issue.prog)               cmd_data <= wr_data;
            if (issue.id_in)              id_mode  <= 1'b1;
            else if (issue.id_out)        id_mode  <= 1'b0;
        end
    end

    assert_one_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulses));

    assert_prog_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pulses.prog |-> (cmd_addr == $past(wr_addr) && cmd_data == $past(wr_data)));

    assert_sect_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pulses.sect |-> (cmd_addr == $past(wr_addr)));

    assert_id_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(id_mode) |-> pulses.id_in);

    assert_id_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(id_mode) |-> pulses.id_out);

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8,
    parameter int CMP_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    output logic              prog_pulse,
    output logic              sect_erase_pulse,
    output logic              chip_erase_pulse,
    output logic              lock_pulse,
    output logic              id_enter_pulse,
    output logic              id_exit_pulse,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic              id_mode
);

    logic      hit_a, hit_b;
    cmd_code_t code;
    cmd_set_t  issue, pulses;

    cmd_match #(.CMP_W(CMP_W), .DATA_W(DATA_W)) u_match (
        .low_addr (wr_addr[CMP_W-1:0]),
        .data     (wr_data),
        .hit_a    (hit_a),
        .hit_b    (hit_b),
        .code     (code)
    );

    cmd_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .busy  (busy),
        .hit_a (hit_a),
        .hit_b (hit_b),
        .code  (code),
        .issue (issue)
    );

    cmd_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (issue),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .pulses   (pulses),
        .cmd_addr (cmd_addr),
        .cmd_data (cmd_data),
        .id_mode  (id_mode)
    );

    always_comb begin
        prog_pulse       = pulses.prog;
        sect_erase_pulse = pulses.sect;
        chip_erase_pulse = pulses.chip;
        lock_pulse       = pulses.lock;
        id_enter_pulse   = pulses.id_in;
        id_exit_pulse    = pulses.id_out;
    end

endmodule

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;

    localparam int CLK_PERIOD = 10;

    localparam int K_PROG = 0, K_SECT = 1, K_CHIP = 2, K_LOCK = 3, K_IDIN = 4, K_IDOUT = 5;

    typedef struct {
        int          kind;
        logic [17:0] addr;
        logic [7:0]  data;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [17:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        busy = 1'b0;
    logic        prog_pulse, sect_erase_pulse, chip_erase_pulse, lock_pulse;
    logic        id_enter_pulse, id_exit_pulse, id_mode;
    logic [17:0] cmd_addr;
    logic [7:0]  cmd_data;

    int checks = 0;
    int fails  = 0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .prog_pulse(prog_pulse), .sect_erase_pulse(sect_erase_pulse),
        .chip_erase_pulse(chip_erase_pulse), .lock_pulse(lock_pulse),
        .id_enter_pulse(id_enter_pulse), .id_exit_pulse(id_exit_pulse),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .id_mode(id_mode)
    );

    task automatic wr(input logic [17:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_cmd(input int k, input logic [17:0] a, input logic [7:0] d, input string r);
        exp_t e;
        e.kind = k; e.addr = a; e.data = d; e.req = r;
        q.push_back(e);
    endtask

    task automatic drain(input string r);
        repeat (3) @(negedge clk);
        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL %s: %0d expected commands missing, expected 0", r, q.size());
            q.delete();
        end
    endtask

    task automatic check_id(input logic exp, input string r);
        checks++;
        if (id_mode !== exp) begin
            fails++;
            $display("FAIL %s: id_mode=%0b expected %0b", r, id_mode, exp);
        end
    endtask

    task automatic prefix(input logic [17:0] hi);
        wr(hi | 18'h05555, 8'hAA);
        wr(hi | 18'h02AAA, 8'h55);
    endtask

    task automatic long_head();
        prefix(18'h0);
        wr(18'h05555, 8'h80);
        prefix(18'h0);
    endtask

    // monitor: compares every observed pulse against the scoreboard head
    always @(negedge clk) begin
        if (rst_n) begin
            int n;
            int k;
            n = prog_pulse + sect_erase_pulse + chip_erase_pulse + lock_pulse
              + id_enter_pulse + id_exit_pulse;
            k = prog_pulse ? K_PROG : sect_erase_pulse ? K_SECT : chip_erase_pulse ? K_CHIP :
                lock_pulse ? K_LOCK : id_enter_pulse ? K_IDIN : K_IDOUT;
            if (n > 1) begin
                checks++; fails++;
                $display("FAIL R11: %0d pulses in one cycle, expected 1", n);
            end else if (n == 1) begin
                checks++;
                if (q.size() == 0) begin
                    fails++;
                    $display("FAIL R8: unexpected command kind %0d, expected none", k);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (k != e.kind) begin
                        fails++;
                        $display("FAIL %s: command kind %0d expected %0d", e.req, k, e.kind);
                    end else if ((k == K_PROG || k == K_SECT) && cmd_addr !== e.addr) begin
                        fails++;
                        $display("FAIL %s: cmd_addr=%h expected %h", e.req, cmd_addr, e.addr);
                    end else if (k == K_PROG && cmd_data !== e.data) begin
                        fails++;
                        $display("FAIL %s: cmd_data=%h expected %h", e.req, cmd_data, e.data);
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        fails++; checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        checks++;
        if ({prog_pulse, sect_erase_pulse, chip_erase_pulse, lock_pulse,
             id_enter_pulse, id_exit_pulse} !== 6'b0) begin
            fails++; $display("FAIL R1: pulses nonzero after reset, expected 000000");
        end
        check_id(1'b0, "R1");

        // R2 program
        prefix(18'h0); wr(18'h05555, 8'hA0);
        expect_cmd(K_PROG, 18'h3ABCD, 8'h5A, "R2");
        wr(18'h3ABCD, 8'h5A);
        drain("R2");
        // R2 program whose data looks like a command byte
        prefix(18'h0); wr(18'h05555, 8'hA0);
        expect_cmd(K_PROG, 18'h05555, 8'hAA, "R2");
        wr(18'h05555, 8'hAA);
        drain("R2");

        // R3 chip erase
        long_head();
        expect_cmd(K_CHIP, 0, 0, "R3");
        wr(18'h05555, 8'h10);
        drain("R3");

        // R4 sector erase at arbitrary address
        long_head();
        expect_cmd(K_SECT, 18'h3A123, 0, "R4");
        wr(18'h3A123, 8'h30);
        drain("R4");

        // R5 lock enable
        long_head();
        expect_cmd(K_LOCK, 0, 0, "R5");
        wr(18'h05555, 8'h40);
        drain("R5");

        // R6 identification entry
        prefix(18'h0);
        expect_cmd(K_IDIN, 0, 0, "R6");
        wr(18'h05555, 8'h90);
        drain("R6");
        check_id(1'b1, "R6");

        // R7 three-write exit
        prefix(18'h0);
        expect_cmd(K_IDOUT, 0, 0, "R7");
        wr(18'h05555, 8'hF0);
        drain("R7");
        check_id(1'b0, "R7");

        // R7 single-write exit at any address
        prefix(18'h0);
        expect_cmd(K_IDIN, 0, 0, "R6");
        wr(18'h05555, 8'h90);
        drain("R6");
        check_id(1'b1, "R6");
        expect_cmd(K_IDOUT, 0, 0, "R7");
        wr(18'h01234, 8'hF0);
        drain("R7");
        check_id(1'b0, "R7");

        // R8 wrong second address, then orphan command bytes
        wr(18'h05555, 8'hAA); wr(18'h02AAB, 8'h55);
        wr(18'h05555, 8'hA0); wr(18'h00100, 8'h12);
        drain("R8");
        // R8 wrong address on sixth write of chip erase
        long_head(); wr(18'h02AAA, 8'h10);
        drain("R8");
        // R8 wrong data in the middle of the long family
        prefix(18'h0); wr(18'h05555, 8'h80); wr(18'h05555, 8'hAB);
        wr(18'h02AAA, 8'h55); wr(18'h05555, 8'h10);
        drain("R8");

        // R9 upper address bits ignored; bit 14 is compared
        prefix(18'h38000); wr(18'h3D555, 8'hA0);
        expect_cmd(K_PROG, 18'h00042, 8'h3C, "R9");
        wr(18'h00042, 8'h3C);
        drain("R9");
        wr(18'h01555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'hA0);
        wr(18'h00042, 8'h3C);
        drain("R9");

        // R10 busy blocks and holds
        busy = 1'b1;
        wr(18'h00010, 8'hF0);
        drain("R10");
        busy = 1'b0;
        prefix(18'h0);
        busy = 1'b1;
        wr(18'h05555, 8'hA0); wr(18'h01234, 8'h77);
        busy = 1'b0;
        wr(18'h05555, 8'hA0);
        expect_cmd(K_PROG, 18'h00123, 8'h5A, "R10");
        wr(18'h00123, 8'h5A);
        drain("R10");

        // R11 back-to-back single exits: each its own one-cycle pulse
        expect_cmd(K_IDOUT, 0, 0, "R11");
        expect_cmd(K_IDOUT, 0, 0, "R11");
        wr(18'h00000, 8'hF0); wr(18'h00001, 8'hF0);
        drain("R11");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule